// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is an 8-bit full-duplex synchronous serial port. A one-byte transmit holding register feeds a shift register that clocks data onto the serial output. A receive shift register collects the serial input on the opposite clock edge and hands each finished byte to a one-byte receive holding register. The transfer clock is either made inside the block from the system clock, through a four-way prescaler and an 8-bit divider, or taken from an external clock pin. The transmitter always produces or follows the clock, so bytes are received only while a byte, or a dummy byte in continuous-receive mode, is being shifted out.

The host side is stream-shaped. A byte is offered on `tx_data` with `tx_valid` and is taken in the cycle where `tx_ready` is high. `tx_ready` is high exactly while the transmit holding register is empty, so the host is held back for the whole time a byte waits there. A received byte is shown on `rx_data` with `rx_valid` and stays there, unchanged, until the host takes it with `rx_ready`. A byte that finishes while the previous one is still unread is not delivered: the overrun flag is set instead. Configuration inputs are plain levels that the host keeps steady during a transfer. The interrupt outputs are one-cycle pulses.

Top module: `sync_serial_port`

## Requirements
- R1: Each transfer shifts exactly 8 bits out on `sdo` and 8 bits in from `sdi`, one bit per transfer-clock period.
- R2: With the internal clock selected, the transfer-clock period is 2*(N+1)*P system-clock cycles. N is `cfg_divisor` (0..255). P is 1, 2, 8 or 32 for `cfg_prescale` codes 0, 1, 2 and 3.
- R3: A transfer begins only while `cfg_tx_en` is 1 and the transmit holding register holds a byte. While `cfg_tx_en` is 0, a written byte stays held (`tx_ready` stays 0).
- R4: When `cfg_cts_en` is 1, a transfer does not begin while `cts_n` is high, and begins once it goes low. When `cfg_cts_en` is 0, `cts_n` has no effect.
- R5: When `cfg_rx_en` was 1 at the start of a transfer, the received byte is loaded into the receive holding register at the end of the transfer, `rx_valid` goes to 1 and `rx_irq` pulses. When it was 0, nothing is received.
- R6: With `cfg_clk_pol` 0 the clock idles high, `sdo` changes on falling edges and `sdi` is sampled on rising edges. With `cfg_clk_pol` 1 the clock idles low and both edges swap.
- R7: `cfg_msb_first` 0 sends and receives bit 0 first. A value of 1 sends and receives bit 7 first.
- R8: `cfg_invert` 1 inverts the line level of both `sdo` and `sdi` relative to the data bytes.
- R9: `cfg_txirq_done` 0 pulses `tx_irq` when a held byte moves into the shift register. A value of 1 pulses it when that byte has been completely shifted out, in the same cycle as `rx_irq`.
- R10: If the receive holding register is still full when the 7th bit of the next byte is sampled, `overrun` goes to 1, that byte is discarded and no `rx_irq` is raised. Taking the held byte clears `overrun`.
- R11: With `cfg_cont_rx` 1 and `cfg_rx_en` 1, taking a received byte starts another transfer with no transmit write. That transfer sends all ones (before inversion) and receives normally.
- R12: With `cfg_rts_en` 1, `rts_n` is 0 while `cfg_rx_en` is 1 and the receive holding register is empty, and 1 otherwise. With `cfg_rts_en` 0, `rts_n` is 0.
- R13: With `cfg_ext_clk` 1, bits move on edges of `sclk_in` (after a two-flop synchronizer), using the same edge roles as R6. A transfer begins only while `sclk_in` is at its idle level.
- R14: `tx_ready` is 1 exactly while the transmit holding register is empty. An offer while it is full is not taken. `rx_data` holds steady while `rx_valid` is 1 and `rx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | Offer of `tx_data` |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Host takes `rx_data` |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext_clk | input | 1 | 1: clock from `sclk_in`; 0: internal divider |
| cfg_clk_pol | input | 1 | Clock polarity (see R6) |
| cfg_msb_first | input | 1 | 1: bit 7 first; 0: bit 0 first |
| cfg_invert | input | 1 | Invert serial data levels |
| cfg_cont_rx | input | 1 | Continuous-receive mode |
| cfg_txirq_done | input | 1 | Transmit interrupt on completion instead of on load |
| cfg_cts_en | input | 1 | Gate transfer start on `cts_n` |
| cfg_rts_en | input | 1 | Drive `rts_n` from receive readiness |
| cfg_prescale | input | 2 | Prescaler code: 0=/1, 1=/2, 2=/8, 3=/32 |
| cfg_divisor | input | 8 | Divider value N |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock output |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Overrun flag |

## Verification
On every cycle, the assertions check the rules that a single edge or a pair of cycles can show. A transfer never begins without transmit enable or against a high CTS. The clock is back at its idle level whenever a transfer ends. A pending receive byte holds steady under back-pressure. Taking a byte clears the overrun flag. A receive pulse always comes with a full buffer, and the divider never emits back-to-back ticks unless it is set to divide by one. Only the bench's scenarios can show the serial content: bit order, inversion, the actual clock period for each prescaler and divider setting, the overrun discard, the dummy transfer of continuous receive, externally clocked transfers and the timing of the two transmit-interrupt points.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PRE_DIV1  = 2'd0,
    PRE_DIV2  = 2'd1,
    PRE_DIV8  = 2'd2,
    PRE_DIV32 = 2'd3
  } pre_sel_e;

  // Terminal count of the prescaler for each selection.
  function automatic logic [4:0] pre_last(input logic [1:0] sel);
    case (pre_sel_e'(sel))
      PRE_DIV1:  pre_last = 5'd0;
      PRE_DIV2:  pre_last = 5'd1;
      PRE_DIV8:  pre_last = 5'd7;
      default:   pre_last = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/sio_sync2.sv
module sio_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sio_baud_gen.sv
module sio_baud_gen
  import sio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       pre_sel,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [4:0]       pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_wrap;
  logic             div_wrap;

  assign pre_wrap = (pre_cnt == pre_last(pre_sel));
  assign div_wrap = (div_cnt == divisor);
  assign tick     = run && pre_wrap && div_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R2: ticks are spaced by (N+1)*P cycles, so only divide-by-one repeats at once
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (divisor != '0 || pre_sel != 2'd0)) |=> !tick);
endmodule

// File: rtl/sio_shift_engine.sv
module sio_shift_engine
  import sio_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ext_sel,
  input  logic              pol,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              tick,
  input  logic              ext_clk_s,
  input  logic              sdi,
  output logic              busy,
  output logic              clk_norm,
  output logic              sdo,
  output logic              seventh,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] PENULT   = CNT_W'(DATA_W - 2);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CNT_W-1:0]  cnt;
  logic              n_int;     // normalized clock: 1 = idle level
  logic              ext_prev;
  logic              sdo_raw;
  logic              ext_n;
  logic              drv_edge;
  logic              smp_edge;
  logic              rx_bit;

  assign ext_n  = ext_clk_s ^ pol;
  assign rx_bit = sdi ^ invert;

  // Drive edge: normalized clock leaves idle. Sample edge: it returns.
  always_comb begin
    if (ext_sel) begin
      drv_edge = busy && ext_prev && !ext_n;
      smp_edge = busy && !ext_prev && ext_n;
    end else begin
      drv_edge = busy && tick && n_int;
      smp_edge = busy && tick && !n_int;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      n_int    <= 1'b1;
      ext_prev <= 1'b1;
      sdo_raw  <= 1'b1;
      tx_sh    <= '0;
      rx_sh    <= '0;
      cnt      <= '0;
      seventh  <= 1'b0;
      done     <= 1'b0;
    end else begin
      ext_prev <= ext_n;
      seventh  <= 1'b0;
      done     <= 1'b0;
      if (!busy) begin
        n_int <= 1'b1;
        if (start) begin
          busy  <= 1'b1;
          tx_sh <= ld_data;
          cnt   <= '0;
        end
      end else begin
        if (!ext_sel && tick) n_int <= !n_int;
        if (drv_edge) begin
          sdo_raw <= msb_first ? tx_sh[DATA_W-1] : tx_sh[0];
          tx_sh   <= msb_first ? (tx_sh << 1) : (tx_sh >> 1);
        end
        if (smp_edge) begin
          rx_sh <= msb_first ? {rx_sh[DATA_W-2:0], rx_bit}
                             : {rx_bit, rx_sh[DATA_W-1:1]};
          cnt   <= cnt + 1'b1;
          if (cnt == PENULT) seventh <= 1'b1;
          if (cnt == LAST_BIT) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign clk_norm = n_int;
  assign sdo      = sdo_raw ^ invert;
  assign rx_byte  = rx_sh;

  // R6: the generated clock is back at its idle level when a transfer ends
  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> n_int);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sio_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic              cfg_ext_clk,
  input  logic              cfg_clk_pol,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic              cfg_cont_rx,
  input  logic              cfg_txirq_done,
  input  logic              cfg_cts_en,
  input  logic              cfg_rts_en,
  input  logic [1:0]        cfg_prescale,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sdo,
  input  logic              sdi,
  input  logic              cts_n,
  output logic              rts_n,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              overrun
);
  logic [DATA_W-1:0] tx_buf;
  logic              tx_full;
  logic [DATA_W-1:0] rx_buf;
  logic              rx_full;
  logic              arm;       // continuous-receive dummy transfer pending
  logic              real_ld;   // current transfer carries a host byte
  logic              rx_act;    // current transfer receives
  logic              ovr_pend;  // current byte is to be discarded
  logic              sclk_s;
  logic              cts_s;
  logic              tick;
  logic              eng_busy;
  logic              eng_clk;
  logic              eng_seventh;
  logic              eng_done;
  logic [DATA_W-1:0] eng_rx;
  logic              start;
  logic              pop;
  logic              ext_idle;

  sio_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_in, cts_n}),
    .q     ({sclk_s, cts_s})
  );

  sio_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (eng_busy && !cfg_ext_clk),
    .pre_sel (cfg_prescale),
    .divisor (cfg_divisor),
    .tick    (tick)
  );

  sio_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ld_data   (tx_full ? tx_buf : {DATA_W{1'b1}}),
    .ext_sel   (cfg_ext_clk),
    .pol       (cfg_clk_pol),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .tick      (tick),
    .ext_clk_s (sclk_s),
    .sdi       (sdi),
    .busy      (eng_busy),
    .clk_norm  (eng_clk),
    .sdo       (sdo),
    .seventh   (eng_seventh),
    .done      (eng_done),
    .rx_byte   (eng_rx)
  );

  assign ext_idle = sclk_s ^ cfg_clk_pol;
  assign pop      = rx_full && rx_ready;
  assign start    = !eng_busy && cfg_tx_en && (tx_full || arm)
                    && (!cfg_cts_en || !cts_s)
                    && (!cfg_ext_clk || ext_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      tx_full  <= 1'b0;
      rx_buf   <= '0;
      rx_full  <= 1'b0;
      arm      <= 1'b0;
      real_ld  <= 1'b0;
      rx_act   <= 1'b0;
      ovr_pend <= 1'b0;
      overrun  <= 1'b0;
      tx_irq   <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
      if (tx_valid && !tx_full) begin
        tx_buf  <= tx_data;
        tx_full <= 1'b1;
      end
      if (start) begin
        if (tx_full) tx_full <= 1'b0;
        real_ld  <= tx_full;
        rx_act   <= cfg_rx_en;
        arm      <= 1'b0;
        ovr_pend <= 1'b0;
        tx_irq   <= tx_full && !cfg_txirq_done;
      end
      if (pop) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
        if (cfg_cont_rx && cfg_rx_en) arm <= 1'b1;
      end
      if (eng_seventh && rx_act && rx_full && !pop) begin
        ovr_pend <= 1'b1;
        overrun  <= 1'b1;
      end
      if (eng_done) begin
        if (rx_act && !ovr_pend) begin
          rx_buf  <= eng_rx;
          rx_full <= 1'b1;
          rx_irq  <= 1'b1;
        end
        if (real_ld && cfg_txirq_done) tx_irq <= 1'b1;
      end
    end
  end

  assign tx_ready = !tx_full;
  assign rx_valid = rx_full;
  assign rx_data  = rx_buf;
  assign sclk_out = eng_clk ^ cfg_clk_pol;
  assign rts_n    = cfg_rts_en ? !(cfg_rx_en && !rx_full) : 1'b0;

  // R3: no transfer begins with the transmitter disabled
  p_start_txen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(cfg_tx_en));
  // R4: no transfer begins against a high clear-to-send when gating is on
  p_cts_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(!cfg_cts_en || !cts_s));
  // R5: a receive pulse always comes with a byte on offer
  p_rx_irq_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);
  // R10: taking the held byte clears the overrun flag
  p_ovr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !overrun);
  // R14: an untaken receive byte holds steady
  p_rx_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic cfg_tx_en = 0, cfg_rx_en = 0, cfg_ext_clk = 0, cfg_clk_pol = 0;
  logic cfg_msb_first = 0, cfg_invert = 0, cfg_cont_rx = 0, cfg_txirq_done = 0;
  logic cfg_cts_en = 0, cfg_rts_en = 0;
  logic [1:0] cfg_prescale = 2'd0;
  logic [7:0] cfg_divisor = 8'd0;
  logic sclk_in = 1'b1;
  logic sclk_out, sdo, rts_n, tx_irq, rx_irq, overrun;
  logic sdi = 1'b1;
  logic cts_n = 1'b0;

  sync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
    .cfg_ext_clk(cfg_ext_clk), .cfg_clk_pol(cfg_clk_pol),
    .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
    .cfg_cont_rx(cfg_cont_rx), .cfg_txirq_done(cfg_txirq_done),
    .cfg_cts_en(cfg_cts_en), .cfg_rts_en(cfg_rts_en),
    .cfg_prescale(cfg_prescale), .cfg_divisor(cfg_divisor),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sdo(sdo), .sdi(sdi),
    .cts_n(cts_n), .rts_n(rts_n), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .overrun(overrun)
  );

  typedef struct packed {
    logic [7:0] tx;
    logic [7:0] sl;
    logic       msb;
    logic       pol;
    logic       inv;
    logic [1:0] pre;
    logic [7:0] div;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0},
    '{8'h81, 8'hC3, 1'b1, 1'b0, 1'b0, 2'd1, 8'd2},
    '{8'h5A, 8'h0F, 1'b0, 1'b1, 1'b0, 2'd2, 8'd1},
    '{8'hF0, 8'h96, 1'b1, 1'b1, 1'b1, 2'd0, 8'd4},
    '{8'h12, 8'hE7, 1'b0, 1'b0, 1'b1, 2'd3, 8'd0},
    '{8'h7E, 8'h01, 1'b1, 1'b1, 1'b0, 2'd1, 8'd0}
  };

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Serial partner: drives sdi on drive edges, captures sdo on sample edges.
  logic [7:0] slv_byte = 8'h00;
  logic [7:0] cap = 8'h00;
  logic       slv_clr = 1'b0;
  logic       prev_norm = 1'b1;
  logic       line_now, norm_now;
  int sidx = 0, cidx = 0, t1 = 0, t2 = 0;
  int txi_cnt = 0, rxi_cnt = 0, txi_cyc = 0, rxi_cyc = 0;

  always @(negedge clk) begin
    line_now = cfg_ext_clk ? sclk_in : sclk_out;
    norm_now = line_now ^ cfg_clk_pol;
    if (slv_clr) begin
      sidx = 0; cidx = 0; cap = 8'h00;
    end else begin
      if (prev_norm && !norm_now && sidx < 8) begin
        sdi = slv_byte[cfg_msb_first ? 7 - sidx : sidx];
        sidx++;
      end
      if (!prev_norm && norm_now && cidx < 8) begin
        cap[cfg_msb_first ? 7 - cidx : cidx] = sdo;
        if (cidx == 0) t1 = cyc;
        if (cidx == 1) t2 = cyc;
        cidx++;
      end
    end
    prev_norm = norm_now;
    if (tx_irq) begin txi_cnt++; txi_cyc = cyc; end
    if (rx_irq) begin rxi_cnt++; rxi_cyc = cyc; end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    tick(1);
    tx_data = b;
    tx_valid = 1'b1;
    while (!tx_ready) tick(1);
    tick(1);
    tx_valid = 1'b0;
  endtask

  task automatic take();
    tick(1);
    rx_ready = 1'b1;
    tick(1);
    rx_ready = 1'b0;
  endtask

  task automatic wait_rx();
    for (int n = 0; n < 3000 && !rx_valid; n++) tick(1);
  endtask

  task automatic slave_reset(input logic [7:0] b);
    tick(1);
    slv_byte = b;
    slv_clr = 1'b1;
    tick(1);
    slv_clr = 1'b0;
  endtask

  task automatic ext_clock_byte();
    for (int k = 0; k < 8; k++) begin
      sclk_in = cfg_clk_pol;
      tick(6);
      sclk_in = !cfg_clk_pol;
      tick(6);
    end
  endtask

  function automatic int pre_factor(input logic [1:0] p);
    case (p)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 32;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vec_t v;
    logic [7:0] mask;
    int n0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // Reset state
    chk(tx_ready == 1'b1, "R14 reset tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R5 reset rx_valid", rx_valid, 0);
    chk(overrun == 1'b0, "R10 reset overrun", overrun, 0);
    chk(sclk_out == 1'b1, "R6 reset idle high", sclk_out, 1);
    chk(rts_n == 1'b0, "R12 reset rts_n", rts_n, 0);

    cfg_tx_en = 1'b1;
    cfg_rx_en = 1'b1;

    // Vector table: order, polarity, inversion, divider
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      cfg_msb_first = v.msb; cfg_clk_pol = v.pol; cfg_invert = v.inv;
      cfg_prescale = v.pre; cfg_divisor = v.div;
      mask = {8{v.inv}};
      slave_reset(v.sl);
      tick(2);
      send(v.tx);
      wait_rx();
      tick(2);
      chk(rx_valid == 1'b1, "R5 byte received", rx_valid, 1);
      chk(rx_data == (v.sl ^ mask), "R1 R7 R8 rx byte", rx_data, v.sl ^ mask);
      chk(cap == (v.tx ^ mask), "R1 R7 R8 line byte", cap, v.tx ^ mask);
      chk(t2 - t1 == 2 * (v.div + 1) * pre_factor(v.pre), "R2 clock period",
          t2 - t1, 2 * (v.div + 1) * pre_factor(v.pre));
      chk(sclk_out == !v.pol, "R6 idle level", sclk_out, !v.pol);
      take();
    end
    cfg_msb_first = 0; cfg_clk_pol = 0; cfg_invert = 0;
    cfg_prescale = 0; cfg_divisor = 0;
    slave_reset(8'h00);

    // R3 and R14: held while transmit disabled, second offer refused
    cfg_tx_en = 1'b0;
    send(8'h3E);
    tx_data = 8'hC1; tx_valid = 1'b1;
    tick(30);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R3 held while disabled", tx_ready, 0);
    chk(cidx == 0, "R3 no clock while disabled", cidx, 0);
    cfg_tx_en = 1'b1;
    wait_rx();
    tick(2);
    chk(cap == 8'h3E, "R14 refused offer not sent", cap, 8'h3E);
    take();

    // R4: clear-to-send gating
    cfg_cts_en = 1'b1; cts_n = 1'b1;
    slave_reset(8'h55);
    send(8'h99);
    tick(30);
    chk(tx_ready == 1'b0 && cidx == 0, "R4 blocked by cts", tx_ready, 0);
    cts_n = 1'b0;
    wait_rx();
    tick(2);
    chk(rx_data == 8'h55, "R4 runs after cts low", rx_data, 8'h55);
    take();
    cfg_cts_en = 1'b0; cts_n = 1'b1;
    slave_reset(8'h66);
    send(8'h44);
    wait_rx();
    tick(2);
    chk(rx_valid == 1'b1 && rx_data == 8'h66, "R4 cts ignored when off", rx_data, 8'h66);
    take();
    cts_n = 1'b0;

    // R9: transmit interrupt points
    cfg_txirq_done = 1'b0;
    slave_reset(8'h11);
    send(8'h22);
    wait_rx();
    tick(2);
    chk(txi_cyc < rxi_cyc - 8, "R9 irq at load", txi_cyc, rxi_cyc);
    take();
    cfg_txirq_done = 1'b1;
    slave_reset(8'h11);
    send(8'h23);
    wait_rx();
    tick(2);
    chk(txi_cyc == rxi_cyc, "R9 irq at completion", txi_cyc, rxi_cyc);
    take();
    cfg_txirq_done = 1'b0;

    // R5: receive disabled
    cfg_rx_en = 1'b0;
    slave_reset(8'hAA);
    send(8'h5C);
    tick(60);
    chk(rx_valid == 1'b0, "R5 nothing received when off", rx_valid, 0);
    chk(cap == 8'h5C, "R5 transmit still runs", cap, 8'h5C);
    cfg_rx_en = 1'b1;

    // R12: request-to-send
    cfg_rts_en = 1'b1;
    tick(1);
    chk(rts_n == 1'b0, "R12 ready for data", rts_n, 0);

    // R10: overrun
    slave_reset(8'h0A);
    send(8'hB0);
    wait_rx();
    tick(2);
    chk(rts_n == 1'b1, "R12 buffer full", rts_n, 1);
    n0 = rxi_cnt;
    slave_reset(8'h0B);
    send(8'hB1);
    tick(60);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    chk(rxi_cnt == n0, "R10 no rx irq on overrun", rxi_cnt, n0);
    chk(rx_data == 8'h0A, "R10 held byte kept", rx_data, 8'h0A);
    take();
    tick(1);
    chk(overrun == 1'b0 && rx_valid == 1'b0, "R10 cleared by take", overrun, 0);
    cfg_rx_en = 1'b0;
    tick(1);
    chk(rts_n == 1'b1, "R12 receive disabled", rts_n, 1);
    cfg_rts_en = 1'b0;
    tick(1);
    chk(rts_n == 1'b0, "R12 function off", rts_n, 0);
    cfg_rx_en = 1'b1;

    // R11: continuous receive
    cfg_cont_rx = 1'b1;
    slave_reset(8'h31);
    send(8'h42);
    wait_rx();
    tick(2);
    chk(rx_data == 8'h31, "R11 first byte", rx_data, 8'h31);
    slave_reset(8'h9C);
    take();
    wait_rx();
    tick(2);
    chk(rx_valid == 1'b1 && rx_data == 8'h9C, "R11 rearmed receive", rx_data, 8'h9C);
    chk(cap == 8'hFF, "R11 dummy ones sent", cap, 8'hFF);
    cfg_cont_rx = 1'b0;
    take();

    // R13: external clock
    cfg_ext_clk = 1'b1;
    sclk_in = 1'b1;
    slave_reset(8'h69);
    tick(4);
    send(8'hC4);
    tick(20);
    chk(rx_valid == 1'b0 && cidx == 0, "R13 waits for external edges", rx_valid, 0);
    ext_clock_byte();
    tick(6);
    chk(rx_valid == 1'b1 && rx_data == 8'h69, "R13 external rx byte", rx_data, 8'h69);
    chk(cap == 8'hC4, "R13 external line byte", cap, 8'hC4);
    take();
    cfg_ext_clk = 1'b0;

    tick(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule